// File: doc/BRIEF.md
# Shadow-Slot Transfer Queue Tracker

This block is the front end of a load/store transfer unit. It keeps a ring of shadow slots. An initiator pulses `lock_req` together with a source ID. If a slot is free, the block grants it in the same cycle and returns the slot index and a context bit. The context bit inverts every time allocation wraps from the last slot back to slot 0. Software can therefore tell a reused slot from its earlier occupant.

Granted slots go to an external packet engine one at a time, in allocation order. The block presents the head slot on `issue_slot` and waits for a single response carrying a 3-bit completion code. Each completion writes the status register with the slot index, the context bit and the code. It also raises the interrupt bit of the source ID that was stored with that slot. A successful completion can have its interrupt withheld by `sup_good`, but its status is still recorded.

An error code freezes the queue. The head slot stays in place and nothing more is issued until software writes a restart or a flush. A restart re-issues the stalled slot and leaves the status as it is. A flush retires the stalled slot and every pending slot with code 111.

The controller is a four-state machine:
- READY: waiting for a pending slot. It goes to BUSY when the ring is non-empty.
- BUSY: the head slot is issued.
  - A good response goes to READY.
  - An error response goes to HALT.
- HALT: stalled.
  - Restart goes to BUSY.
  - Flush goes to FLUSH. Flush wins if both are written together.
- FLUSH: one slot is retired per cycle. It goes to READY after the last pending slot.

Top module: `xfer_queue_tracker`

## Requirements
- R1: When a slot is free, a `lock_req` gives `lock_grant`=1 in the same cycle. `lock_slot` is the next allocation index, starting at 0 and counting up. `lock_ctx` starts at 0 after reset and inverts each time allocation wraps from slot SLOTS-1 to slot 0.
- R2: When all SLOTS slots are held, a `lock_req` gives `lock_busy`=1 and `lock_grant`=0. No slot is taken, and the next grant after a slot frees returns the index that would have been next.
- R3: Slots are issued strictly in allocation order. `issue_valid` with `issue_slot` presents only the oldest pending slot. The next slot is presented only after a response to the current one.
- R4: Each response to an issued slot writes `stat_slot`, `stat_ctx` and `stat_code` from that slot, visible in the cycle after the response. The codes are:
  - 000: success.
  - 001: non-posted timeout.
  - 011: error response.
  - Any non-zero code counts as an error.
- R5: A successful completion sets `irq[src]`, where src is the source ID given with the slot's lock. When `sup_good`=1 the bit is not set, but the status is still written.
- R6: An error completion always sets `irq[src]` and stalls the queue:
  - `stalled`=1 and `issue_valid`=0.
  - Responses are ignored and the status is unchanged.
  - The head index and context stop advancing.
  - Locks are still granted while stalled.
- R7: A `cmd_restart` while stalled leaves the status register unchanged. Issue resumes with the same stalled slot.
- R8: A `cmd_flush` while stalled retires the stalled slot and all pending slots, oldest first, one per cycle. Each retirement writes the status with code 111. No interrupt is set. `lock_req` is answered busy while the flush runs. Afterwards the ring is empty and `stalled`=0.
- R9: Each 1 bit in `irq_clr` clears the matching `irq` bit without affecting the stall. A set of the same bit in the same cycle wins over the clear.
- R10: After reset: `irq`=0, `stalled`=0, `issue_valid`=0, the status register is 0, and the ring is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lock_req | input | 1 | Request a shadow slot this cycle |
| lock_src | input | $clog2(NSRC) | Source ID stored with the requested slot |
| lock_grant | output | 1 | Slot granted this cycle |
| lock_busy | output | 1 | Request refused this cycle (full or flushing) |
| lock_slot | output | $clog2(SLOTS) | Granted slot index |
| lock_ctx | output | 1 | Granted context bit |
| issue_valid | output | 1 | Head slot is issued to the packet engine |
| issue_slot | output | $clog2(SLOTS) | Index of the issued slot |
| resp_valid | input | 1 | Engine response for the issued slot |
| resp_code | input | 3 | Completion code of the response |
| sup_good | input | 1 | Withhold interrupts of successful completions |
| cmd_restart | input | 1 | Resume from the stalled slot |
| cmd_flush | input | 1 | Retire stalled and pending slots with code 111 |
| irq_clr | input | NSRC | Per-source interrupt clear mask |
| irq | output | NSRC | Per-source interrupt bits |
| stalled | output | 1 | Queue frozen by an error or being flushed |
| stat_slot | output | $clog2(SLOTS) | Slot index of the latest completion |
| stat_ctx | output | 1 | Context bit of the latest completion |
| stat_code | output | 3 | Code of the latest completion |

## Verification
The hardest state to reach is a stall with extra slots queued behind the failing one. Reaching it takes locks granted during HALT and a lock attempt that lands inside the multi-cycle FLUSH. The stimulus builds this by taking three locks, failing the first and retrying it, failing the second, locking once more while halted, and only then flushing. During the flush it fires a lock, which must come back busy.

The context bit only shows its behaviour across wraps. The bench therefore drives a small four-slot ring through several full laps, with mixed lock and complete patterns. It predicts every slot, context, code and interrupt arithmetically from its own ring counters.

// File: rtl/xqt_pkg.sv
package xqt_pkg;

    typedef enum logic [1:0] {
        S_READY = 2'd0,
        S_BUSY  = 2'd1,
        S_HALT  = 2'd2,
        S_FLUSH = 2'd3
    } xqt_state_e;

    localparam logic [2:0] CODE_OK      = 3'b000;
    localparam logic [2:0] CODE_TIMEOUT = 3'b001;
    localparam logic [2:0] CODE_ERRRESP = 3'b011;
    localparam logic [2:0] CODE_FLUSHED = 3'b111;

endpackage

// File: rtl/xqt_slot_ring.sv
module xqt_slot_ring #(
    parameter int SLOTS = 8,
    parameter int SRCW  = 4,
    localparam int IW   = (SLOTS > 1) ? $clog2(SLOTS) : 1,
    localparam int CW   = $clog2(SLOTS + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            alloc,
    input  logic [SRCW-1:0] alloc_src,
    input  logic            release_i,
    output logic            full,
    output logic            empty,
    output logic            last,
    output logic [IW-1:0]   tail_idx,
    output logic            tail_ctx,
    output logic [IW-1:0]   head_idx,
    output logic            head_ctx,
    output logic [SRCW-1:0] head_src
);

    logic [CW-1:0]   cnt_q;
    logic [SRCW-1:0] src_q [SLOTS];

    assign full  = (cnt_q == CW'(SLOTS));
    assign empty = (cnt_q == '0);
    assign last  = (cnt_q == CW'(1));
    assign head_src = src_q[head_idx];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tail_idx <= '0;
            tail_ctx <= 1'b0;
        end else if (alloc) begin
            if (tail_idx == IW'(SLOTS - 1)) begin
                tail_idx <= '0;
                tail_ctx <= ~tail_ctx;
            end else begin
                tail_idx <= tail_idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_idx <= '0;
            head_ctx <= 1'b0;
        end else if (release_i) begin
            if (head_idx == IW'(SLOTS - 1)) begin
                head_idx <= '0;
                head_ctx <= ~head_ctx;
            end else begin
                head_idx <= head_idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (alloc && !release_i)
            cnt_q <= cnt_q + 1'b1;
        else if (!alloc && release_i)
            cnt_q <= cnt_q - 1'b1;
    end

    for (genvar g = 0; g < SLOTS; g++) begin : g_src
        always_ff @(posedge clk) begin
            if (!rst_n)
                src_q[g] <= '0;
            else if (alloc && tail_idx == IW'(g))
                src_q[g] <= alloc_src;
        end
    end

    AST_RING_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        alloc && !release_i |-> !full) else $error("ring overflow"); // R2

    AST_RING_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        release_i |-> !empty) else $error("ring underflow"); // R3

endmodule

// File: rtl/xqt_irq_bank.sv
module xqt_irq_bank #(
    parameter int NSRC = 16,
    localparam int SRCW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            set_en,
    input  logic [SRCW-1:0] set_id,
    input  logic [NSRC-1:0] clr_mask,
    output logic [NSRC-1:0] irq
);

    logic [NSRC-1:0] set_vec;

    always_comb begin
        set_vec = '0;
        if (set_en)
            set_vec[set_id] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            irq <= '0;
        else
            irq <= (irq & ~clr_mask) | set_vec;
    end

    AST_IRQ_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> irq[$past(set_id)]) else $error("irq set lost"); // R9

endmodule

// File: rtl/xfer_queue_tracker.sv
module xfer_queue_tracker
    import xqt_pkg::*;
#(
    parameter int SLOTS = 8,
    parameter int NSRC  = 16,
    localparam int IW   = (SLOTS > 1) ? $clog2(SLOTS) : 1,
    localparam int SRCW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            lock_req,
    input  logic [SRCW-1:0] lock_src,
    output logic            lock_grant,
    output logic            lock_busy,
    output logic [IW-1:0]   lock_slot,
    output logic            lock_ctx,
    output logic            issue_valid,
    output logic [IW-1:0]   issue_slot,
    input  logic            resp_valid,
    input  logic [2:0]      resp_code,
    input  logic            sup_good,
    input  logic            cmd_restart,
    input  logic            cmd_flush,
    input  logic [NSRC-1:0] irq_clr,
    output logic [NSRC-1:0] irq,
    output logic            stalled,
    output logic [IW-1:0]   stat_slot,
    output logic            stat_ctx,
    output logic [2:0]      stat_code
);

    xqt_state_e state_q, state_d;

    logic            full, empty, last;
    logic [IW-1:0]   tail_idx, head_idx;
    logic            tail_ctx, head_ctx;
    logic [SRCW-1:0] head_src;
    logic            take, good, bad, flush_step, release_s, irq_set;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= S_READY;
        else
            state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_READY: if (!empty) state_d = S_BUSY;
            S_BUSY: begin
                if (good)     state_d = S_READY;
                else if (bad) state_d = S_HALT;
            end
            S_HALT: begin
                if (cmd_flush)        state_d = S_FLUSH;
                else if (cmd_restart) state_d = S_BUSY;
            end
            S_FLUSH: if (last) state_d = S_READY;
            default: state_d = S_READY;
        endcase
    end

    // outputs and control pulses
    always_comb begin
        take        = (state_q == S_BUSY) && resp_valid;
        good        = take && (resp_code == CODE_OK);
        bad         = take && (resp_code != CODE_OK);
        flush_step  = (state_q == S_FLUSH);
        release_s   = good || flush_step;
        irq_set     = bad || (good && !sup_good);
        issue_valid = (state_q == S_BUSY);
        issue_slot  = head_idx;
        stalled     = (state_q == S_HALT) || (state_q == S_FLUSH);
        lock_grant  = lock_req && !full && !flush_step;
        lock_busy   = lock_req && !lock_grant;
        lock_slot   = tail_idx;
        lock_ctx    = tail_ctx;
    end

    // status register: latest completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_slot <= '0;
            stat_ctx  <= 1'b0;
            stat_code <= CODE_OK;
        end else if (take || flush_step) begin
            stat_slot <= head_idx;
            stat_ctx  <= head_ctx;
            stat_code <= flush_step ? CODE_FLUSHED : resp_code;
        end
    end

    xqt_slot_ring #(.SLOTS(SLOTS), .SRCW(SRCW)) u_ring (
        .clk       (clk),
        .rst_n     (rst_n),
        .alloc     (lock_grant),
        .alloc_src (lock_src),
        .release_i (release_s),
        .full      (full),
        .empty     (empty),
        .last      (last),
        .tail_idx  (tail_idx),
        .tail_ctx  (tail_ctx),
        .head_idx  (head_idx),
        .head_ctx  (head_ctx),
        .head_src  (head_src)
    );

    xqt_irq_bank #(.NSRC(NSRC)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_en   (irq_set),
        .set_id   (head_src),
        .clr_mask (irq_clr),
        .irq      (irq)
    );

    AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == S_HALT && !cmd_restart && !cmd_flush |=> stalled && !issue_valid)
        else $error("stall released without command"); // R6

    AST_HEAD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == S_HALT |=> $stable(head_idx) && $stable(head_ctx))
        else $error("head moved while stalled"); // R6

    AST_ERR_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        bad |=> irq[$past(head_src)] && stalled)
        else $error("error not signalled"); // R6

    AST_RESTART_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == S_HALT && cmd_restart && !cmd_flush |=> $stable(stat_code) && issue_valid)
        else $error("restart altered status"); // R7

    AST_FLUSH_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == S_FLUSH |=> stat_code == CODE_FLUSHED)
        else $error("flush code wrong"); // R8

    AST_ISSUE_ONLY_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> !empty) else $error("issue from empty ring"); // R3

endmodule

// File: tb/sim_xfer_queue_tracker.sv
module sim_xfer_queue_tracker;

    localparam int CLK_PERIOD = 10;
    localparam int SLOTS = 4;
    localparam int NSRC  = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lock_req = 1'b0;
    logic [3:0]  lock_src = '0;
    logic        lock_grant, lock_busy, lock_ctx;
    logic [1:0]  lock_slot;
    logic        issue_valid;
    logic [1:0]  issue_slot;
    logic        resp_valid = 1'b0;
    logic [2:0]  resp_code = '0;
    logic        sup_good = 1'b0;
    logic        cmd_restart = 1'b0;
    logic        cmd_flush = 1'b0;
    logic [15:0] irq_clr = '0;
    logic [15:0] irq;
    logic        stalled;
    logic [1:0]  stat_slot;
    logic        stat_ctx;
    logic [2:0]  stat_code;

    always #(CLK_PERIOD/2) clk = ~clk;

    xfer_queue_tracker #(.SLOTS(SLOTS), .NSRC(NSRC)) u0 (
        .clk(clk), .rst_n(rst_n),
        .lock_req(lock_req), .lock_src(lock_src),
        .lock_grant(lock_grant), .lock_busy(lock_busy),
        .lock_slot(lock_slot), .lock_ctx(lock_ctx),
        .issue_valid(issue_valid), .issue_slot(issue_slot),
        .resp_valid(resp_valid), .resp_code(resp_code),
        .sup_good(sup_good), .cmd_restart(cmd_restart), .cmd_flush(cmd_flush),
        .irq_clr(irq_clr), .irq(irq), .stalled(stalled),
        .stat_slot(stat_slot), .stat_ctx(stat_ctx), .stat_code(stat_code)
    );

    int nchecks = 0;
    int nerrs   = 0;
    bit done    = 1'b0;

    int          e_tail = 0, e_head = 0, e_cnt = 0;
    bit          e_tctx = 0, e_hctx = 0;
    logic [3:0]  e_src [SLOTS];
    logic [15:0] e_irq = '0;
    logic [1:0]  e_sslot = '0;
    bit          e_sctx = 0;
    logic [2:0]  e_scode = '0;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        nchecks++;
        if (act !== exp) begin
            nerrs++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic check_stat(input string req);
        chk(req, "stat_slot", 32'(stat_slot), 32'(e_sslot));
        chk(req, "stat_ctx",  32'(stat_ctx),  32'(e_sctx));
        chk(req, "stat_code", 32'(stat_code), 32'(e_scode));
    endtask

    task automatic do_lock(input logic [3:0] src);
        @(negedge clk);
        lock_req = 1'b1;
        lock_src = src;
        #1;
        if (e_cnt < SLOTS) begin
            chk("R1", "lock_grant", 32'(lock_grant), 32'd1);
            chk("R1", "lock_slot",  32'(lock_slot),  32'(e_tail));
            chk("R1", "lock_ctx",   32'(lock_ctx),   32'(e_tctx));
        end else begin
            chk("R2", "lock_busy",  32'(lock_busy),  32'd1);
            chk("R2", "lock_grant", 32'(lock_grant), 32'd0);
        end
        @(posedge clk);
        #1;
        lock_req = 1'b0;
        if (e_cnt < SLOTS) begin
            e_src[e_tail] = src;
            e_cnt++;
            if (e_tail == SLOTS-1) begin e_tail = 0; e_tctx = ~e_tctx; end
            else e_tail++;
        end
    endtask

    task automatic complete(input logic [2:0] code, input logic [15:0] clr);
        logic [15:0] setv;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (issue_valid) break;
        end
        chk("R3", "issue_valid", 32'(issue_valid), 32'd1);
        chk("R3", "issue_slot",  32'(issue_slot),  32'(e_head));
        resp_valid = 1'b1;
        resp_code  = code;
        irq_clr    = clr;
        @(posedge clk);
        #1;
        resp_valid = 1'b0;
        irq_clr    = '0;
        e_sslot = 2'(e_head);
        e_sctx  = e_hctx;
        e_scode = code;
        setv = '0;
        if (code != 3'b000 || !sup_good) setv[e_src[e_head]] = 1'b1;
        e_irq = (e_irq & ~clr) | setv;
        check_stat("R4");
        chk(code == 3'b000 ? "R5" : "R6", "irq", 32'(irq), 32'(e_irq));
        chk("R6", "stalled", 32'(stalled), 32'(code != 3'b000));
        if (code == 3'b000) begin
            e_cnt--;
            if (e_head == SLOTS-1) begin e_head = 0; e_hctx = ~e_hctx; end
            else e_head++;
        end
    endtask

    task automatic clear_irq(input logic [15:0] mask, input bit exp_stall);
        @(negedge clk);
        irq_clr = mask;
        @(posedge clk);
        #1;
        irq_clr = '0;
        e_irq &= ~mask;
        chk("R9", "irq after clear", 32'(irq), 32'(e_irq));
        chk("R9", "stall kept", 32'(stalled), 32'(exp_stall));
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            nerrs++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrs);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        // R10 reset state
        chk("R10", "irq", 32'(irq), 32'd0);
        chk("R10", "stalled", 32'(stalled), 32'd0);
        chk("R10", "issue_valid", 32'(issue_valid), 32'd0);
        check_stat("R10");

        // R1 fill the ring, R2 full refusal
        for (int i = 0; i < SLOTS; i++) do_lock(4'(i));
        do_lock(4'd9);
        do_lock(4'd10);
        // R3 R4 R5 drain in order with interrupts
        for (int i = 0; i < SLOTS; i++) complete(3'b000, 16'h0);
        clear_irq(16'h000f, 1'b0);

        // R1 R5 several laps with suppressed good interrupts
        sup_good = 1'b1;
        for (int lap = 0; lap < 3; lap++) begin
            for (int i = 0; i < SLOTS; i++) do_lock(4'(lap * 4 + i));
            for (int i = 0; i < SLOTS; i++) complete(3'b000, 16'h0);
        end
        // mixed lock/complete pattern
        sup_good = 1'b0;
        for (int k = 0; k < 5; k++) begin
            do_lock(4'(k + 2));
            do_lock(4'(k + 7));
            complete(3'b000, 16'h0);
        end
        while (e_cnt > 0) complete(3'b000, 16'h0);
        // R9 set wins over a simultaneous clear of the same bit
        do_lock(4'd12);
        complete(3'b000, 16'h1000);
        clear_irq(16'hffff, 1'b0);

        // R6 error stalls the queue
        do_lock(4'd5);
        do_lock(4'd6);
        do_lock(4'd7);
        complete(3'b001, 16'h0);
        clear_irq(16'h0020, 1'b1);
        // R6 responses ignored while stalled
        @(negedge clk);
        resp_valid = 1'b1;
        resp_code  = 3'b000;
        @(posedge clk);
        #1;
        resp_valid = 1'b0;
        check_stat("R6");
        chk("R6", "issue_valid stalled", 32'(issue_valid), 32'd0);
        chk("R6", "irq unchanged", 32'(irq), 32'(e_irq));
        repeat (3) @(posedge clk);
        #1;
        chk("R6", "still stalled", 32'(stalled), 32'd1);

        // R7 restart keeps status and reissues same slot
        @(negedge clk);
        cmd_restart = 1'b1;
        @(posedge clk);
        #1;
        cmd_restart = 1'b0;
        check_stat("R7");
        chk("R7", "issue_slot", 32'(issue_slot), 32'(e_head));
        chk("R7", "stalled", 32'(stalled), 32'd0);
        complete(3'b000, 16'h0);
        complete(3'b011, 16'h0);
        do_lock(4'd8);   // R6 lock granted while stalled

        // R8 flush three pending slots
        @(negedge clk);
        cmd_flush = 1'b1;
        @(posedge clk);
        #1;
        cmd_flush = 1'b0;
        @(negedge clk);
        lock_req = 1'b1;
        lock_src = 4'd3;
        #1;
        chk("R8", "lock_busy in flush", 32'(lock_busy), 32'd1);
        chk("R8", "lock_grant in flush", 32'(lock_grant), 32'd0);
        @(posedge clk);
        #1;
        lock_req = 1'b0;
        repeat (4) @(posedge clk);
        #1;
        while (e_cnt > 0) begin
            e_sslot = 2'(e_head);
            e_sctx  = e_hctx;
            e_scode = 3'b111;
            e_cnt--;
            if (e_head == SLOTS-1) begin e_head = 0; e_hctx = ~e_hctx; end
            else e_head++;
        end
        check_stat("R8");
        chk("R8", "stalled", 32'(stalled), 32'd0);
        chk("R8", "issue_valid", 32'(issue_valid), 32'd0);
        chk("R8", "irq", 32'(irq), 32'(e_irq));
        // R8 ring is empty again: a full set of locks is granted
        for (int i = 0; i < SLOTS; i++) do_lock(4'(i + 1));
        do_lock(4'd0);
        for (int i = 0; i < SLOTS; i++) complete(3'b000, 16'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrs);
        $finish;
    end

endmodule